// File: doc/BRIEF.md
# Sequential Two's-Complement Fraction Multiplier

This block multiplies two signed 4-bit operands over several clock cycles. It uses one accumulator register, a register for the multiplicand and a 5-bit adder that can subtract. The operands can be read as integers or as fractions. As fractions, each operand has a sign bit followed by three fraction bits. The product then has its binary point after the top two bits.

A pulse on `start` while the block is idle captures both operands. The block then runs four steps, one for each bit of the multiplier, starting at the least significant bit. In each step, the block first adds the multiplicand into the upper half of the accumulator when the current multiplier bit is 1. It then shifts the whole accumulator right by one place and keeps the sign. The last step handles the multiplier's sign bit. In that step the block subtracts the multiplicand instead of adding it: it inverts the multiplicand and adds one.

`done` is high for one cycle when the result is ready. The product stays on `product` until the next accepted start.

Top module: `frac_mul_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `done` is 0 and `product` is 0.
- R2: The block stays idle until `start` is 1. While idle with `start` low, `done` stays 0 and `product` does not change.
- R3: After `start` is sampled high at an idle clock edge, `done` rises after the eighth following clock edge. It stays high for exactly one cycle, then the block returns to idle.
- R4: When `done` is 1, `product` holds the 8-bit two's-complement product of `mcand` and `mplier` as captured at the start edge, for all 256 operand pairs.
- R5: Each partial-sum add is done 5 bits wide with the multiplicand sign-extended. Its carry out of the top bit is dropped, so a negative multiplicand gives the correct product.
- R6: Each shift moves the 9-bit accumulator right by one place and copies its sign bit into the vacated top bit.
- R7: Only the step for the multiplier's sign bit (bit 3), and only when that bit is 1, subtracts the multiplicand: it adds the inverted multiplicand plus one. A negative multiplier therefore gives the correct product.
- R8: In fraction form, -1.0 times -1.0 (operands 4'b1000 and 4'b1000) gives product 8'b0100_0000. With the binary point after the top two bits, this reads as +1.0.
- R9: A `start` pulse while a multiplication is in progress is ignored. The result is still that of the operands captured at the accepted start.
- R10: After `done`, `product` keeps its value until the next accepted start, even when the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a multiplication when the block is idle |
| mcand | input | 4 | Multiplicand, two's complement |
| mplier | input | 4 | Multiplier, two's complement |
| product | output | 8 | Signed product. As a fraction, the binary point is after bit 6 |
| done | output | 1 | One-cycle pulse when `product` is valid |

## Verification
On every cycle, the assertions check four things:
- `done` is a single-cycle pulse that follows a shift.
- The subtract control is raised only in the step for the multiplier's sign bit.
- The accumulator's sign bit survives each shift.
- An operation in progress cannot fall back to idle early, and the product holds steady while the block is idle.

The bench's scenarios are needed for everything else: the arithmetic value across all 256 operand pairs, the -1.0 × -1.0 fraction corner, a start pulse ignored mid-operation, and the product held after completion while the inputs change.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    // Default operand width; the product is twice this wide.
    localparam int unsigned OPW = 4;

    // Sequencer states: each multiplier bit takes an add cycle and then a shift cycle.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADD   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } fmul_state_e;

    // Strobes from the sequencer to the datapath.
    typedef struct packed {
        logic load;   // capture the operands, clear the upper accumulator
        logic add;    // write the adder output into the upper accumulator
        logic cm;     // subtract: invert the multiplicand and add one
        logic shift;  // arithmetic right shift of the whole accumulator
        logic done;   // result valid
    } fmul_ctl_t;

    // Sign-extends a 4-bit value to 5 bits (used by the bench-facing defaults).
    function automatic logic [OPW:0] sext_op(input logic [OPW-1:0] v);
        return {v[OPW-1], v};
    endfunction

endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
    import fmul_pkg::*;
#(
    parameter  int W  = OPW,
    localparam int SW = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             lsb,
    output fmul_state_e      st_o,
    output logic [SW-1:0]    step_o,
    output fmul_ctl_t        ctl_o
);

    fmul_state_e   st_q;
    logic [SW-1:0] step_q;
    logic          last_step;

    assign last_step = (step_q == SW'(W - 1));

    // Moore-style strobes, except that add and cm follow the multiplier bit in view.
    always_comb begin
        ctl_o = '0;
        unique case (st_q)
            ST_IDLE:  ctl_o.load  = start;
            ST_ADD: begin
                ctl_o.add = lsb;
                ctl_o.cm  = lsb && last_step;
            end
            ST_SHIFT: ctl_o.shift = 1'b1;
            ST_DONE:  ctl_o.done  = 1'b1;
            default:  ctl_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_ADD;
                        step_q <= '0;
                    end
                end
                ST_ADD:   st_q <= ST_SHIFT;
                ST_SHIFT: begin
                    if (last_step) begin
                        st_q <= ST_DONE;
                    end else begin
                        st_q   <= ST_ADD;
                        step_q <= step_q + SW'(1);
                    end
                end
                ST_DONE:  st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    assign st_o   = st_q;
    assign step_o = step_q;

endmodule

// File: rtl/fmul_addsub.sv
module fmul_addsub
    import fmul_pkg::*;
#(
    parameter int W = OPW
) (
    input  logic [W:0]   hi,
    input  logic [W-1:0] mcand,
    input  logic         cm,
    output logic [W:0]   sum
);

    logic [W:0] opnd;
    logic [W:0] opnd_x;

    // One guard bit keeps the sign of the partial sum; the carry out is dropped.
    assign opnd   = {mcand[W-1], mcand};
    assign opnd_x = cm ? ~opnd : opnd;
    assign sum    = hi + opnd_x + (W + 1)'(cm);

endmodule

// File: rtl/fmul_acc.sv
module fmul_acc
    import fmul_pkg::*;
#(
    parameter  int W  = OPW,
    localparam int AW = 2 * W + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  fmul_ctl_t    ctl,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    input  logic [W:0]   sum,
    output logic [AW-1:0] acc_o,
    output logic [W-1:0] mcand_o
);

    logic [AW-1:0] acc_q;
    logic [W-1:0]  mcand_q;

    // Upper W+1 bits hold the partial sum; the lower W bits start as the multiplier.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            mcand_q <= '0;
        end else if (ctl.load) begin
            acc_q   <= {(W + 1)'(0), mplier_in};
            mcand_q <= mcand_in;
        end else if (ctl.add) begin
            acc_q[AW-1:W] <= sum;
        end else if (ctl.shift) begin
            acc_q <= {acc_q[AW-1], acc_q[AW-1:1]};
        end
    end

    assign acc_o   = acc_q;
    assign mcand_o = mcand_q;

endmodule

// File: rtl/frac_mul_seq.sv
module frac_mul_seq
    import fmul_pkg::*;
#(
    parameter  int W  = OPW,
    localparam int PW = 2 * W,
    localparam int AW = 2 * W + 1,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  mcand,
    input  logic [W-1:0]  mplier,
    output logic [PW-1:0] product,
    output logic          done
);

    fmul_state_e   st;
    logic [SW-1:0] step;
    fmul_ctl_t     ctl;
    logic [AW-1:0] acc;
    logic [W-1:0]  mcand_q;
    logic [W:0]    sum;

    fmul_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .lsb    (acc[0]),
        .st_o   (st),
        .step_o (step),
        .ctl_o  (ctl)
    );

    fmul_addsub #(.W(W)) u_addsub (
        .hi    (acc[AW-1:W]),
        .mcand (mcand_q),
        .cm    (ctl.cm),
        .sum   (sum)
    );

    fmul_acc #(.W(W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .sum       (sum),
        .acc_o     (acc),
        .mcand_o   (mcand_q)
    );

    // After the last shift the top bit duplicates bit PW-1; the product is the low 2W bits.
    assign product = acc[PW-1:0];
    assign done    = ctl.done;

endmodule

// File: rtl/fmul_chk.sv
module fmul_chk
    import fmul_pkg::*;
#(
    parameter  int W  = OPW,
    localparam int PW = 2 * W,
    localparam int AW = 2 * W + 1,
    localparam int SW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic [PW-1:0] product,
    input fmul_state_e   st,
    input logic [SW-1:0] step,
    input fmul_ctl_t     ctl,
    input logic [AW-1:0] acc
);

    // R3: done is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: done is raised right after a shift cycle
    p_done_after_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift && step == SW'(W - 1)) |=> done);

    // R7: subtraction happens only on the sign-bit step, together with an add
    p_sub_sign_step_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.cm |-> (ctl.add && step == SW'(W - 1) && acc[0]));

    // R6: the sign bit is kept through each shift
    p_shift_sign_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.shift |=> (acc[AW-1] == $past(acc[AW-1]) && acc[AW-2] == $past(acc[AW-1])));

    // R9: a running operation cannot fall back to idle early
    p_busy_no_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADD || st == ST_SHIFT) |=> st != ST_IDLE);

    // R2 and R10: the product holds while idle with start low
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> $stable(product));

endmodule

bind frac_mul_seq fmul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .product (product),
    .st      (st),
    .step    (step),
    .ctl     (ctl),
    .acc     (acc)
);

// File: tb/test_frac_mul_seq.sv
module test_frac_mul_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] mcand;
    logic [3:0] mplier;
    logic [7:0] product;
    logic       done;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // Reference model: cycles since an accepted start (-1 = idle), expected result.
    int         m_cnt = -1;
    logic [7:0] m_exp = '0;
    int         m_a   = 0;
    int         m_b   = 0;

    always #5 clk = ~clk;

    frac_mul_seq i_frac_mul_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product),
        .done    (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced at each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = -1;
        end else if (m_cnt < 0) begin
            if (start) begin
                m_cnt = 0;
                m_a   = $signed(mcand);
                m_b   = $signed(mplier);
                m_exp = 8'(m_a * m_b);
            end
        end else begin
            m_cnt++;
            if (m_cnt == 9) m_cnt = -1;
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst && cyc > 0) begin
            check(done == (m_cnt == 8), "R3 done timing", int'(done), int'(m_cnt == 8));
            if (m_cnt == 8) begin
                if (m_a == -8 && m_b == -8)
                    check(product == m_exp, "R8 fraction -1 x -1", product, m_exp);
                else if (m_b < 0)
                    check(product == m_exp, "R7 negative multiplier", product, m_exp);
                else if (m_a < 0)
                    check(product == m_exp, "R5 R6 negative multiplicand", product, m_exp);
                else
                    check(product == m_exp, "R4 product", product, m_exp);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run_mult(input int a, input int b);
        @(negedge clk);
        mcand  = 4'(a);
        mplier = 4'(b);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    logic [7:0] held;

    initial begin
        rst    = 1'b1;
        start  = 1'b0;
        mcand  = '0;
        mplier = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(product == 8'h00, "R1 product in reset", product, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(product == 8'h00, "R1 product after reset", product, 0);

        // R2: idle with start low, operands toggling
        mcand  = 4'd5;
        mplier = 4'd3;
        repeat (6) @(negedge clk);
        check(done == 1'b0, "R2 idle done", done, 0);
        check(product == 8'h00, "R2 idle product", product, 0);

        // R4 R5 R6 R7 R8: exhaustive operand pairs
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                run_mult(a, b);
            end
        end

        // R8: explicit fraction corner, then R10 hold with changing inputs
        run_mult(-8, -8);
        check(product == 8'b0100_0000, "R8 -1.0 x -1.0 = +1.0", product, 64);
        held   = product;
        mcand  = 4'd7;
        mplier = 4'd6;
        repeat (5) @(negedge clk);
        check(product == held, "R10 product held", product, held);
        check(done == 1'b0, "R10 done low while held", done, 0);

        // R9: start pulse during an operation is ignored
        @(negedge clk);
        mcand  = 4'(3);
        mplier = 4'(-5);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (2) @(negedge clk);
        mcand  = 4'(7);
        mplier = 4'(7);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R9 done at original time", done, 1);
        check(product == 8'(-15), "R9 busy start ignored", $signed(product), -15);
        @(negedge clk);
        check(done == 1'b0, "R3 done single cycle", done, 0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule